// File: doc/BRIEF.md
# Line Record Store with Sequential Host Reader

This block keeps received video-line records in an on-chip byte memory and hands them to a host one byte at a time. A capture port writes each record as a burst of fixed length, by default 44 bytes. The first two bytes carry the line, field and data-type tag. They are followed by a 2-byte address group and 40 payload bytes, and every data format uses that same layout. The memory is 2048 bytes. Its first 44-byte slot is set aside for control data, so stored records begin at byte 44. The 45 slots after it are used as a circular ring.

The host sees a single data port. Each read request returns the next byte in the order the bytes arrived, and a hidden pointer advances by itself. Three pointer commands let the host drop everything and start over, go back to the first byte of the record being read, or give up the rest of that record and move on to the next one. The block reports the number of complete records waiting, the number of records handed back so far, empty and full, and a sticky flag that is set when a record was lost because every slot was taken.

Top module: `pktbuf_store`

## Requirements
- R1: After reset, pkt_avail and pkt_done are 0, buf_empty is 1, buf_full is 0, ovf_flag is 0 and host_byte is 0x00.
- R2: A record is accepted as follows. A cycle with cap_valid=1 and cap_first=1 opens the record and stores its byte 0. The next 43 cycles with cap_valid=1 store bytes 1 to 43. pkt_avail rises by one on the clock edge that stores byte 43, and not before.
- R3: If cap_first arrives while pkt_avail equals 45 (buf_full=1), the whole record is dropped and none of its bytes are stored. ovf_flag is then set and stays set until a rewind or reset. pkt_avail never goes above 45.
- R4: host_byte is valid in the cycle after host_rd. Bytes come out in the order they were captured, and host_byte holds its value until the next host_rd.
- R5: Reading byte 43 of a record releases that record: pkt_avail falls by one and pkt_done rises by one. The next read returns byte 0 of the next record. Slots are reused in a circle, so slot 44 is followed by slot 0.
- R6: A host_rd while buf_empty=1 returns 0x00 and leaves the read position and both counts unchanged.
- R7: host_restart moves the read position back to byte 0 of the current record and does not release it.
- R8: host_skip releases the current record even if it was only partly read, and the next read returns byte 0 of the next record. host_skip while empty has no effect.
- R9: host_rewind returns both the capture and the read position to slot 0. It discards all stored records and any record still being captured, and clears pkt_avail, pkt_done and ovf_flag.
- R10: Commands have a fixed priority: rewind, then skip, then restart. A host_rd in the same cycle as any command returns 0x00 and does not move the read position.
- R11: A cap_first in the middle of a record abandons the partial record, and the new record takes its slot. Bytes with cap_valid=1 and cap_first=0 are ignored when no record is open, for example after byte 43 or after a dropped record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_valid | input | 1 | A capture byte is present |
| cap_first | input | 1 | The capture byte is byte 0 of a new record |
| cap_byte | input | 8 | Capture byte |
| host_rd | input | 1 | Read request on the data port |
| host_rewind | input | 1 | Discard all records and return to slot 0 |
| host_restart | input | 1 | Go back to byte 0 of the current record |
| host_skip | input | 1 | Release the current record and go to the next |
| host_byte | output | 8 | Data port, valid the cycle after host_rd |
| pkt_avail | output | 6 | Number of complete records not yet released |
| pkt_done | output | 16 | Number of records released since reset or rewind |
| buf_empty | output | 1 | pkt_avail is 0 |
| buf_full | output | 1 | pkt_avail is 45 |
| ovf_flag | output | 1 | Sticky flag: a record was dropped |

## Verification
A table drives the main capture-and-read path with records read in several ways: read out whole, read in part and then skipped, skipped before any byte is read, and read in part, restarted and skipped. Comparing byte values tells a restart apart from a skip and shows whether release happens on the last byte. Directed cases then fill every slot and offer one more record, which separates a dropped record from a stored one. Reading past the ring end checks the wrap. Other cases apply several commands in one cycle, since each priority order leads to a different next byte, and read an empty store, where the byte that follows shows whether the pointer moved.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

  typedef enum logic [2:0] {
    HC_IDLE,
    HC_READ,
    HC_RESTART,
    HC_SKIP,
    HC_REWIND
  } host_cmd_e;

  // Fixed priority: rewind, skip, restart, then a plain read.
  function automatic host_cmd_e host_decode(input logic rd, input logic restart,
                                            input logic skip, input logic rewind);
    if (rewind)       return HC_REWIND;
    else if (skip)    return HC_SKIP;
    else if (restart) return HC_RESTART;
    else if (rd)      return HC_READ;
    else              return HC_IDLE;
  endfunction

endpackage

// File: rtl/pktbuf_ram.sv
module pktbuf_ram #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register with synchronous reset, updated only on an enabled read.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/pktbuf_wr_ctl.sv
module pktbuf_wr_ctl #(
  parameter int ROWS      = 45,
  parameter int ROW_BYTES = 44,
  parameter int DATA_W    = 8,
  parameter int ROW_W     = $clog2(ROWS),
  parameter int OFF_W     = $clog2(ROW_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              cap_valid,
  input  logic              cap_first,
  input  logic [DATA_W-1:0] cap_byte,
  input  logic              full,
  output logic              we,
  output logic [ROW_W-1:0]  w_row,
  output logic [OFF_W-1:0]  w_off,
  output logic [DATA_W-1:0] w_byte,
  output logic              commit,
  output logic              drop
);

  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(ROW_BYTES - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic             in_rec;
  logic [ROW_W-1:0] row_q;
  logic [OFF_W-1:0] off_q;
  logic             start;

  always_comb begin
    start  = cap_valid & cap_first;
    drop   = start & full & ~flush;
    we     = ~flush & cap_valid & (cap_first ? ~full : in_rec);
    w_row  = row_q;
    w_off  = cap_first ? '0 : off_q;
    w_byte = cap_byte;
    commit = we & ~cap_first & (off_q == LAST_OFF);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      in_rec <= 1'b0;
      row_q  <= '0;
      off_q  <= '0;
    end else if (start) begin
      // A new record always restarts the current slot; a full ring drops it.
      in_rec <= ~full;
      off_q  <= full ? '0 : OFF_W'(1);
    end else if (cap_valid && in_rec) begin
      if (off_q == LAST_OFF) begin
        in_rec <= 1'b0;
        off_q  <= '0;
        row_q  <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pktbuf_rd_ctl.sv
module pktbuf_rd_ctl
  import pktbuf_pkg::*;
#(
  parameter int ROWS      = 45,
  parameter int ROW_BYTES = 44,
  parameter int ROW_W     = $clog2(ROWS),
  parameter int OFF_W     = $clog2(ROW_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_rd,
  input  logic             host_restart,
  input  logic             host_skip,
  input  logic             host_rewind,
  input  logic             empty,
  output logic             re,
  output logic [ROW_W-1:0] r_row,
  output logic [OFF_W-1:0] r_off,
  output logic             force_zero,
  output logic             release_row
);

  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(ROW_BYTES - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  host_cmd_e        cmd;
  logic [ROW_W-1:0] row_q;
  logic [OFF_W-1:0] off_q;

  always_comb begin
    cmd         = host_decode(host_rd, host_restart, host_skip, host_rewind);
    re          = (cmd == HC_READ) & ~empty;
    release_row = ((cmd == HC_SKIP) & ~empty) | (re & (off_q == LAST_OFF));
    r_row       = row_q;
    r_off       = off_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_zero <= 1'b1;
    end else if (host_rd) begin
      force_zero <= ~re;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cmd == HC_REWIND) begin
      row_q <= '0;
      off_q <= '0;
    end else if (release_row) begin
      row_q <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
      off_q <= '0;
    end else if (cmd == HC_RESTART) begin
      off_q <= '0;
    end else if (re) begin
      off_q <= off_q + 1'b1;
    end
  end

endmodule

// File: rtl/pktbuf_level.sv
module pktbuf_level #(
  parameter int ROWS   = 45,
  parameter int DONE_W = 16,
  parameter int CNT_W  = $clog2(ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              commit,
  input  logic              release_row,
  input  logic              drop,
  output logic [CNT_W-1:0]  avail_q,
  output logic [DONE_W-1:0] done_q,
  output logic              empty_q,
  output logic              full_q,
  output logic              ovf_q
);

  logic [CNT_W-1:0] avail_n;

  always_comb begin
    avail_n = avail_q + CNT_W'(commit) - CNT_W'(release_row);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      avail_q <= '0;
      done_q  <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      avail_q <= avail_n;
      done_q  <= done_q + DONE_W'(release_row);
      empty_q <= (avail_n == '0);
      full_q  <= (avail_n == CNT_W'(ROWS));
      ovf_q   <= ovf_q | drop;
    end
  end

endmodule

// File: rtl/pktbuf_store.sv
module pktbuf_store #(
  parameter int RAM_BYTES = 2048,
  parameter int ROW_BYTES = 44,
  parameter int NUM_ROWS  = 45,
  parameter int RSV_ROWS  = 1,
  parameter int DATA_W    = 8,
  parameter int DONE_W    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cap_valid,
  input  logic                         cap_first,
  input  logic [DATA_W-1:0]            cap_byte,
  input  logic                         host_rd,
  input  logic                         host_rewind,
  input  logic                         host_restart,
  input  logic                         host_skip,
  output logic [DATA_W-1:0]            host_byte,
  output logic [$clog2(NUM_ROWS+1)-1:0] pkt_avail,
  output logic [DONE_W-1:0]            pkt_done,
  output logic                         buf_empty,
  output logic                         buf_full,
  output logic                         ovf_flag
);

  localparam int AW    = $clog2(RAM_BYTES);
  localparam int ROW_W = $clog2(NUM_ROWS);
  localparam int OFF_W = $clog2(ROW_BYTES);
  localparam int CNT_W = $clog2(NUM_ROWS + 1);
  localparam int BASE  = RSV_ROWS * ROW_BYTES;   // ring starts after the control slot

  logic              we, re, commit, drop, release_row, force_zero;
  logic [ROW_W-1:0]  w_row, r_row;
  logic [OFF_W-1:0]  w_off, r_off;
  logic [DATA_W-1:0] w_byte, ram_q;
  logic [AW-1:0]     waddr, raddr;

  pktbuf_wr_ctl #(
    .ROWS(NUM_ROWS), .ROW_BYTES(ROW_BYTES), .DATA_W(DATA_W)
  ) wr_i (
    .clk(clk), .rst(rst), .flush(host_rewind),
    .cap_valid(cap_valid), .cap_first(cap_first), .cap_byte(cap_byte),
    .full(buf_full),
    .we(we), .w_row(w_row), .w_off(w_off), .w_byte(w_byte),
    .commit(commit), .drop(drop)
  );

  pktbuf_rd_ctl #(
    .ROWS(NUM_ROWS), .ROW_BYTES(ROW_BYTES)
  ) rd_i (
    .clk(clk), .rst(rst),
    .host_rd(host_rd), .host_restart(host_restart),
    .host_skip(host_skip), .host_rewind(host_rewind),
    .empty(buf_empty),
    .re(re), .r_row(r_row), .r_off(r_off),
    .force_zero(force_zero), .release_row(release_row)
  );

  pktbuf_level #(
    .ROWS(NUM_ROWS), .DONE_W(DONE_W)
  ) lvl_i (
    .clk(clk), .rst(rst), .flush(host_rewind),
    .commit(commit), .release_row(release_row), .drop(drop),
    .avail_q(pkt_avail), .done_q(pkt_done),
    .empty_q(buf_empty), .full_q(buf_full), .ovf_q(ovf_flag)
  );

  always_comb begin
    waddr = AW'(BASE + int'(w_row) * ROW_BYTES + int'(w_off));
    raddr = AW'(BASE + int'(r_row) * ROW_BYTES + int'(r_off));
  end

  pktbuf_ram #(
    .DEPTH(RAM_BYTES), .DATA_W(DATA_W)
  ) ram_i (
    .clk(clk), .rst(rst),
    .we(we), .waddr(waddr), .wdata(w_byte),
    .re(re), .raddr(raddr), .rdata(ram_q)
  );

  assign host_byte = force_zero ? '0 : ram_q;

endmodule

// File: rtl/pktbuf_chk.sv
module pktbuf_chk #(
  parameter int NUM_ROWS = 45,
  parameter int CNT_W    = 6,
  parameter int DONE_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_valid,
  input logic              cap_first,
  input logic              host_rd,
  input logic              host_rewind,
  input logic              host_restart,
  input logic              host_skip,
  input logic [7:0]        host_byte,
  input logic [CNT_W-1:0]  pkt_avail,
  input logic [DONE_W-1:0] pkt_done,
  input logic              buf_empty,
  input logic              buf_full,
  input logic              ovf_flag
);

  p_avail_bound_r3: assert property (@(posedge clk) disable iff (rst)
    pkt_avail <= CNT_W'(NUM_ROWS));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    cap_valid && cap_first && buf_full && !host_rewind |=> ovf_flag);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !host_rewind |=> ovf_flag);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_byte));

  p_done_step_r5: assert property (@(posedge clk) disable iff (rst)
    !host_rewind |=> (pkt_done == $past(pkt_done)) ||
                     (pkt_done == DONE_W'($past(pkt_done) + 1'b1)));

  p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
    host_rd && buf_empty && !host_rewind && !host_skip && !host_restart
    |=> host_byte == 8'h00 && $stable(pkt_done));

  p_restart_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    host_restart && !host_rewind && !host_skip |=> $stable(pkt_done));

  p_rewind_clear_r9: assert property (@(posedge clk) disable iff (rst)
    host_rewind |=> pkt_avail == '0 && pkt_done == '0 && !ovf_flag && buf_empty);

  p_cmd_blocks_read_r10: assert property (@(posedge clk) disable iff (rst)
    host_rd && (host_rewind || host_skip || host_restart) |=> host_byte == 8'h00);

endmodule

bind pktbuf_store pktbuf_chk #(
  .NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W), .DONE_W(DONE_W)
) chk_i (
  .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_first(cap_first),
  .host_rd(host_rd), .host_rewind(host_rewind), .host_restart(host_restart),
  .host_skip(host_skip), .host_byte(host_byte), .pkt_avail(pkt_avail),
  .pkt_done(pkt_done), .buf_empty(buf_empty), .buf_full(buf_full),
  .ovf_flag(ovf_flag)
);

// File: tb/pktbuf_store_tb.sv
module pktbuf_store_tb_top;

  localparam int ROWS = 45;
  localparam int RB   = 44;

  typedef struct packed {
    logic [7:0] seed;
    logic [7:0] nrd;
    logic       restart;
  } vec_t;

  // seed, bytes read before the optional restart, restart flag
  localparam vec_t VECS [6] = '{
    '{8'h11, 8'd44, 1'b0},
    '{8'h2A, 8'd0,  1'b0},
    '{8'h35, 8'd10, 1'b1},
    '{8'h4C, 8'd43, 1'b0},
    '{8'h5E, 8'd20, 1'b1},
    '{8'h60, 8'd1,  1'b0}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       cap_valid, cap_first, host_rd, host_rewind, host_restart, host_skip;
  logic [7:0] cap_byte, host_byte;
  logic [5:0] pkt_avail;
  logic [15:0] pkt_done;
  logic       buf_empty, buf_full, ovf_flag;

  int  n_checks = 0;
  int  n_errors = 0;
  int  exp_done = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  pktbuf_store dut_i (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_first(cap_first),
    .cap_byte(cap_byte), .host_rd(host_rd), .host_rewind(host_rewind),
    .host_restart(host_restart), .host_skip(host_skip), .host_byte(host_byte),
    .pkt_avail(pkt_avail), .pkt_done(pkt_done), .buf_empty(buf_empty),
    .buf_full(buf_full), .ovf_flag(ovf_flag)
  );

  function automatic logic [7:0] pat(input logic [7:0] s, input int k);
    return 8'(int'(s) + k * 7);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic cap(input logic first, input logic [7:0] b);
    cap_valid = 1'b1; cap_first = first; cap_byte = b;
    @(negedge clk);
    cap_valid = 1'b0; cap_first = 1'b0;
  endtask

  task automatic host(input logic rd, input logic rs, input logic sk, input logic rw);
    host_rd = rd; host_restart = rs; host_skip = sk; host_rewind = rw;
    @(negedge clk);
    host_rd = 1'b0; host_restart = 1'b0; host_skip = 1'b0; host_rewind = 1'b0;
  endtask

  task automatic cap_pkt(input logic [7:0] seed, input bit chk);
    int base = int'(pkt_avail);
    for (int k = 0; k < RB; k++) begin
      if (chk && k == RB - 1) check("R2 avail before last byte", int'(pkt_avail), base);
      cap(k == 0, pat(seed, k));
    end
    if (chk) check("R2 avail after last byte", int'(pkt_avail), base + 1);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] exp);
    host(1'b1, 1'b0, 1'b0, 1'b0);
    check(tag, int'(host_byte), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cap_valid = 0; cap_first = 0; cap_byte = 0;
    host_rd = 0; host_rewind = 0; host_restart = 0; host_skip = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 avail", int'(pkt_avail), 0);
    check("R1 done", int'(pkt_done), 0);
    check("R1 empty", int'(buf_empty), 1);
    check("R1 full", int'(buf_full), 0);
    check("R1 ovf", int'(ovf_flag), 0);
    check("R1 byte", int'(host_byte), 0);

    // Table: R2 capture, R4 order, R5 release on last byte, R7 restart, R8 partial skip
    for (int v = 0; v < 6; v++) begin
      int pos;
      cap_pkt(VECS[v].seed, 1'b1);
      for (int k = 0; k < int'(VECS[v].nrd); k++) rd_chk("R4 byte order", pat(VECS[v].seed, k));
      pos = int'(VECS[v].nrd);
      if (VECS[v].restart) begin
        host(1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 no release", int'(pkt_avail), 1);
        rd_chk("R7 restart byte0", pat(VECS[v].seed, 0));
        rd_chk("R7 restart byte1", pat(VECS[v].seed, 1));
        pos = 2;
      end
      if (pos != RB) host(1'b0, 1'b0, 1'b1, 1'b0);
      exp_done++;
      check("R5 R8 avail after release", int'(pkt_avail), 0);
      check("R5 R8 done count", int'(pkt_done), exp_done);
    end

    // R3 fill all slots, then one more record is dropped
    host(1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < ROWS; i++) cap_pkt(8'(i * 3 + 1), 1'b0);
    check("R3 avail full", int'(pkt_avail), ROWS);
    check("R3 full flag", int'(buf_full), 1);
    check("R3 ovf clear", int'(ovf_flag), 0);
    cap_pkt(8'hEE, 1'b0);
    check("R3 ovf set", int'(ovf_flag), 1);
    check("R3 avail capped", int'(pkt_avail), ROWS);
    for (int i = 0; i < ROWS; i++) begin
      rd_chk("R3 stored record", pat(8'(i * 3 + 1), 0));
      host(1'b0, 1'b0, 1'b1, 1'b0);
    end
    check("R3 dropped not stored", int'(pkt_avail), 0);
    check("R8 done after skips", int'(pkt_done), ROWS);

    // R5 wrap from the last slot to slot 0
    cap_pkt(8'hA5, 1'b1);
    cap_pkt(8'hB6, 1'b1);
    for (int k = 0; k < RB; k++) rd_chk("R5 wrapped record", pat(8'hA5, k));
    check("R5 release on last byte", int'(pkt_avail), 1);
    rd_chk("R5 next record byte0", pat(8'hB6, 0));
    check("R3 ovf sticky", int'(ovf_flag), 1);

    // R9 rewind discards stored and partial records
    cap(1'b1, 8'hC7); cap(1'b0, 8'hC8); cap(1'b0, 8'hC9);
    host(1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 avail", int'(pkt_avail), 0);
    check("R9 done", int'(pkt_done), 0);
    check("R9 ovf", int'(ovf_flag), 0);
    check("R9 empty", int'(buf_empty), 1);
    for (int k = 0; k < 5; k++) cap(1'b0, 8'h77);
    check("R11 stray bytes ignored", int'(pkt_avail), 0);
    cap_pkt(8'hD8, 1'b1);
    for (int k = 0; k < RB; k++) rd_chk("R9 fresh record", pat(8'hD8, k));

    // R10 command priority and blocked reads
    cap_pkt(8'h13, 1'b1);
    cap_pkt(8'h24, 1'b1);
    for (int k = 0; k < 3; k++) rd_chk("R4 read", pat(8'h13, k));
    host(1'b1, 1'b1, 1'b0, 1'b0);
    check("R10 read with command gives zero", int'(host_byte), 0);
    rd_chk("R10 restart applied, read ignored", pat(8'h13, 0));
    host(1'b0, 1'b1, 1'b1, 1'b0);
    check("R10 skip beats restart avail", int'(pkt_avail), 1);
    rd_chk("R10 skip beats restart byte", pat(8'h24, 0));
    host(1'b0, 1'b0, 1'b1, 1'b1);
    check("R10 rewind beats skip avail", int'(pkt_avail), 0);
    check("R10 rewind beats skip done", int'(pkt_done), 0);

    // R6 empty read, R8 skip while empty
    rd_chk("R6 empty read zero", 8'h00);
    check("R6 done unchanged", int'(pkt_done), 0);
    host(1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 skip when empty", int'(pkt_done), 0);
    cap_pkt(8'h39, 1'b1);
    rd_chk("R6 pointer unmoved", pat(8'h39, 0));
    repeat (3) @(negedge clk);
    check("R4 byte held", int'(host_byte), int'(pat(8'h39, 0)));

    // R11 abandoned partial record and stray bytes
    cap(1'b1, pat(8'h4A, 0));
    for (int k = 1; k < 10; k++) cap(1'b0, pat(8'h4A, k));
    cap_pkt(8'h5B, 1'b1);
    for (int k = 0; k < 3; k++) cap(1'b0, 8'h99);
    check("R11 avail", int'(pkt_avail), 2);
    host(1'b0, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < RB; k++) rd_chk("R11 replacement record", pat(8'h5B, k));
    check("R11 drained", int'(pkt_avail), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule